// File: doc/BRIEF.md
# Multichannel DAC SPI register interface

This block is the serial front end of a multichannel digital-to-analog converter. A host writes 24-bit frames over a four-wire serial link. Each frame carries a two-bit mode, a six-bit address and a sixteen-bit payload. The mode selects one of three register banks that every channel has: the output code, the offset trim and the gain trim. The fourth mode value reaches a small shared space. That space holds the global control bit, one 14-bit offset DAC per reference group, and a register that requests a readback.

The output codes, the per-channel offset DAC values and the power-down state appear directly on ports. An analog core that is not part of this block consumes them. Readback takes two frames. A first frame names the register type and address. During the next frame the block shifts out the value that was captured when the first frame was committed. Chip select goes high between the two frames.

All serial inputs are oversampled in the system clock domain. No logic runs on the serial clock.

Top module: `mcdac_spi_regs`

## Requirements
- R1: A frame is captured MSB first on falling SCLK edges while `spi_csn` is low. Bits 23:22 hold the mode, bits 21:16 the address and bits 15:0 the payload. The frame is committed when `spi_csn` rises, and only if exactly 24 falling edges arrived. A frame of any other length changes nothing.
- R2: Mode 3 writes the output code of channel `addr-8`, for addresses 8 to 8+NUM_CH-1. That code appears on `chan_code[16*ch +: 16]`.
- R3: Mode 2 writes the channel's offset trim and mode 1 writes its gain trim. Both are visible through readback.
- R4: In mode 0, address 1 is the control register. Payload bit 0 sets or clears `pwr_down`, and the other payload bits have no effect on it.
- R5: In mode 0, address 2+g writes payload bits 13:0 into the offset DAC of reference group g, for g < NUM_GRP. The upper payload bits are discarded.
- R6: A mode 0 write to address 5 selects a readback. Payload bits 15:13 give the type: 0 is code, 1 is the alternate code, 2 is offset trim, 3 is gain trim and 4 is shared space. Payload bits 12:7 give the address. During the next frame, `spi_miso` returns the value in bits 15:0 with bits 23:16 at zero. A new bit is launched on each rising SCLK edge. A frame that follows any other committed frame returns all zeros. `spi_miso` is low while deselected.
- R7: Channel ch uses the offset DAC of group min(ch / CH_PER_GRP, NUM_GRP-1), and `chan_ofs_dac[14*ch +: 14]` shows it.
- R8: After reset, every code is 0x8000 and every offset trim is 0x8000. Every gain trim is all ones (masked as in R10). Every group offset DAC is 0x2000, and `pwr_down` is 0.
- R9: A write to an address that maps to no register, or to a channel index at or above NUM_CH, changes nothing. A readback of such an address returns zero. Readback type 1 returns the same value as type 0. Readback types 5 to 7 return zero.
- R10: With CODE_BITS below 16, codes and trims are left-justified. The low 16-CODE_BITS bits of each stored value are forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial readback data to host |
| chan_code | output | NUM_CH*16 | Output code of every channel, channel 0 in the low bits |
| chan_ofs_dac | output | NUM_CH*14 | Group offset DAC value applying to every channel |
| pwr_down | output | 1 | Global power-down request |

## Verification
The checks assume that each SCLK phase, and each gap between frames, lasts several system clocks. Edges are found only after a two-stage synchronizer. They also assume that chip select stays high for more than one clock after a frame, so a commit never overlaps a newly started frame. The stimulus holds every SCLK phase for ten clocks and leaves twenty idle clocks between frames. It changes MOSI only on the rising SCLK edge, well clear of the sampling edge. Under these conditions, outputs change only in the cycle after a commit, at most one channel is written per commit, and MISO stays low while the part is deselected.

// File: rtl/mcdac_pkg.sv
package mcdac_pkg;

    localparam int FRAME_BITS = 24;
    localparam int WORD_BITS  = 16;
    localparam int OFS_BITS   = 14;
    localparam int CHAN_BASE  = 8;

    typedef enum logic [1:0] {
        MD_SPECIAL = 2'd0,
        MD_GAIN    = 2'd1,
        MD_OFFSET  = 2'd2,
        MD_CODE    = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e       mode;
        logic [5:0]  addr;
        logic [15:0] data;
    } frame_t;

    // shared-space addresses
    localparam logic [5:0] SF_CTRL  = 6'd1;
    localparam logic [5:0] SF_GOFS0 = 6'd2;
    localparam logic [5:0] SF_RBSEL = 6'd5;

    // readback type codes
    localparam logic [2:0] RB_CODE     = 3'd0;
    localparam logic [2:0] RB_CODE_ALT = 3'd1;
    localparam logic [2:0] RB_OFFSET   = 3'd2;
    localparam logic [2:0] RB_GAIN     = 3'd3;
    localparam logic [2:0] RB_SPECIAL  = 3'd4;

    localparam logic [15:0]         RST_CODE = 16'h8000;
    localparam logic [15:0]         RST_TRIM = 16'h8000;
    localparam logic [OFS_BITS-1:0] RST_GOFS = 14'h2000;

    function automatic int group_of(int ch, int per_grp, int n_grp);
        int g;
        g = ch / per_grp;
        return (g >= n_grp) ? n_grp - 1 : g;
    endfunction

    function automatic logic [WORD_BITS-1:0] code_mask(int bits);
        logic [WORD_BITS-1:0] m;
        m = '1;
        m = m << (WORD_BITS - bits);
        return m;
    endfunction

endpackage

// File: rtl/mcdac_spi_link.sv
module mcdac_spi_link
    import mcdac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  spi_sclk,
    input  logic                  spi_csn,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  cs_act,
    output logic                  commit,
    output frame_t                frame
);

    localparam int CNT_MAX = FRAME_BITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [2:0] sclk_s;
    logic [2:0] csn_s;
    logic [1:0] mosi_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s <= '0;
            csn_s  <= '1;
            mosi_s <= '0;
        end else begin
            sclk_s <= {sclk_s[1:0], spi_sclk};
            csn_s  <= {csn_s[1:0], spi_csn};
            mosi_s <= {mosi_s[0], spi_mosi};
        end
    end

    logic sclk_rise, sclk_fall, sel_start, sel_end;
    assign sclk_rise = ~sclk_s[2] & sclk_s[1];
    assign sclk_fall = sclk_s[2] & ~sclk_s[1];
    assign sel_start = csn_s[2] & ~csn_s[1];
    assign sel_end   = ~csn_s[2] & csn_s[1];
    assign cs_act    = ~csn_s[1];

    logic [FRAME_BITS-1:0] rx_sr;
    logic [CNT_W-1:0]      bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sr   <= '0;
            bit_cnt <= '0;
        end else if (sel_start) begin
            bit_cnt <= '0;
        end else if (cs_act && sclk_fall) begin
            rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_s[1]};
            if (bit_cnt != CNT_W'(CNT_MAX))
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            commit <= 1'b0;
            frame  <= '0;
        end else begin
            commit <= sel_end && (bit_cnt == CNT_W'(FRAME_BITS));
            if (sel_end)
                frame <= frame_t'(rx_sr);
        end
    end

    logic [FRAME_BITS-1:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr    <= '0;
            spi_miso <= 1'b0;
        end else if (sel_start) begin
            tx_sr    <= tx_word;
            spi_miso <= 1'b0;
        end else if (!cs_act) begin
            spi_miso <= 1'b0;
        end else if (sclk_rise) begin
            spi_miso <= tx_sr[FRAME_BITS-1];
            tx_sr    <= {tx_sr[FRAME_BITS-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/mcdac_regbank.sv
module mcdac_regbank
    import mcdac_pkg::*;
#(
    parameter int NUM_CH     = 24,
    parameter int CH_PER_GRP = 8,
    parameter int NUM_GRP    = 2,
    parameter int CODE_BITS  = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit,
    input  frame_t                       frm,
    output logic [NUM_CH*WORD_BITS-1:0]  chan_code,
    output logic [NUM_CH*OFS_BITS-1:0]   chan_ofs_dac,
    output logic                         pwr_down,
    output logic [FRAME_BITS-1:0]        tx_word,
    output logic [NUM_CH-1:0]            ch_we
);

    localparam logic [WORD_BITS-1:0] MASK     = code_mask(CODE_BITS);
    localparam logic [WORD_BITS-1:0] RST_GAIN = MASK;

    logic [NUM_CH*WORD_BITS-1:0]  code_all, trim_all, gain_all;
    logic [NUM_GRP*OFS_BITS-1:0]  gofs_all;
    logic                         is_sf;

    assign is_sf = commit && (frm.mode == MD_SPECIAL);

    // per-channel register triplets
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int GRP = group_of(i, CH_PER_GRP, NUM_GRP);
        logic [WORD_BITS-1:0] code_r, trim_r, gain_r;

        assign ch_we[i] = commit && (frm.mode != MD_SPECIAL)
                          && (frm.addr == 6'(CHAN_BASE + i));

        always_ff @(posedge clk) begin
            if (rst) begin
                code_r <= RST_CODE & MASK;
                trim_r <= RST_TRIM & MASK;
                gain_r <= RST_GAIN;
            end else if (ch_we[i]) begin
                case (frm.mode)
                    MD_CODE:   code_r <= frm.data & MASK;
                    MD_OFFSET: trim_r <= frm.data & MASK;
                    MD_GAIN:   gain_r <= frm.data & MASK;
                    default:   ;
                endcase
            end
        end

        assign code_all[i*WORD_BITS +: WORD_BITS] = code_r;
        assign trim_all[i*WORD_BITS +: WORD_BITS] = trim_r;
        assign gain_all[i*WORD_BITS +: WORD_BITS] = gain_r;
        assign chan_ofs_dac[i*OFS_BITS +: OFS_BITS] = gofs_all[GRP*OFS_BITS +: OFS_BITS];
    end

    assign chan_code = code_all;

    // group offset DACs
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [OFS_BITS-1:0] gofs_r;
        always_ff @(posedge clk) begin
            if (rst)
                gofs_r <= RST_GOFS;
            else if (is_sf && frm.addr == SF_GOFS0 + 6'(g))
                gofs_r <= frm.data[OFS_BITS-1:0];
        end
        assign gofs_all[g*OFS_BITS +: OFS_BITS] = gofs_r;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pwr_down <= 1'b0;
        else if (is_sf && frm.addr == SF_CTRL)
            pwr_down <= frm.data[0];
    end

    // readback selection
    logic [2:0]           rb_type;
    logic [5:0]           rb_addr;
    logic [WORD_BITS-1:0] rb_val;

    assign rb_type = frm.data[15:13];
    assign rb_addr = frm.data[12:7];

    always_comb begin
        rb_val = '0;
        case (rb_type)
            RB_CODE, RB_CODE_ALT: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (rb_addr == 6'(CHAN_BASE + i))
                        rb_val = code_all[i*WORD_BITS +: WORD_BITS];
            end
            RB_OFFSET: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (rb_addr == 6'(CHAN_BASE + i))
                        rb_val = trim_all[i*WORD_BITS +: WORD_BITS];
            end
            RB_GAIN: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (rb_addr == 6'(CHAN_BASE + i))
                        rb_val = gain_all[i*WORD_BITS +: WORD_BITS];
            end
            RB_SPECIAL: begin
                if (rb_addr == SF_CTRL)
                    rb_val = {15'd0, pwr_down};
                for (int g = 0; g < NUM_GRP; g++)
                    if (rb_addr == SF_GOFS0 + 6'(g))
                        rb_val = {2'b00, gofs_all[g*OFS_BITS +: OFS_BITS]};
            end
            default: rb_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            tx_word <= '0;
        else if (commit)
            tx_word <= (is_sf && frm.addr == SF_RBSEL) ? {8'h00, rb_val} : '0;
    end

endmodule

// File: rtl/mcdac_spi_regs.sv
module mcdac_spi_regs
    import mcdac_pkg::*;
#(
    parameter int NUM_CH     = 24,
    parameter int CH_PER_GRP = 8,
    parameter int NUM_GRP    = 2,
    parameter int CODE_BITS  = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        spi_sclk,
    input  logic                        spi_csn,
    input  logic                        spi_mosi,
    output logic                        spi_miso,
    output logic [NUM_CH*WORD_BITS-1:0] chan_code,
    output logic [NUM_CH*OFS_BITS-1:0]  chan_ofs_dac,
    output logic                        pwr_down
);

    logic                  cs_act;
    logic                  commit;
    frame_t                frame;
    logic [FRAME_BITS-1:0] tx_word;
    logic [NUM_CH-1:0]     ch_we;

    mcdac_spi_link u_link (
        .clk      (clk),
        .rst      (rst),
        .spi_sclk (spi_sclk),
        .spi_csn  (spi_csn),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .tx_word  (tx_word),
        .cs_act   (cs_act),
        .commit   (commit),
        .frame    (frame)
    );

    mcdac_regbank #(
        .NUM_CH     (NUM_CH),
        .CH_PER_GRP (CH_PER_GRP),
        .NUM_GRP    (NUM_GRP),
        .CODE_BITS  (CODE_BITS)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .commit       (commit),
        .frm          (frame),
        .chan_code    (chan_code),
        .chan_ofs_dac (chan_ofs_dac),
        .pwr_down     (pwr_down),
        .tx_word      (tx_word),
        .ch_we        (ch_we)
    );

endmodule

// File: rtl/mcdac_spi_regs_chk.sv
module mcdac_spi_regs_chk #(
    parameter int NUM_CH = 24
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_act,
    input logic                 commit,
    input logic [NUM_CH-1:0]    ch_we,
    input logic [NUM_CH*16-1:0] chan_code,
    input logic                 pwr_down,
    input logic                 spi_miso
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1: a frame is committed only once the host has deselected
    a_r1_commit_deselected: assert property (@(posedge clk) disable iff (rst)
        commit |-> !cs_act);

    // R2: one commit writes at most one channel
    a_r2_single_channel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_we));

    // R2: codes move only right after a commit
    a_r2_codes_hold: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(commit) |-> $stable(chan_code));

    // R4: power-down moves only right after a commit
    a_r4_pd_hold: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(commit) |-> $stable(pwr_down));

    // R6: readback line is quiet while deselected
    a_r6_miso_quiet: assert property (@(posedge clk) disable iff (rst)
        armed && !cs_act && !$past(cs_act) |-> !spi_miso);

endmodule

bind mcdac_spi_regs mcdac_spi_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .commit    (commit),
    .ch_we     (ch_we),
    .chan_code (chan_code),
    .pwr_down  (pwr_down),
    .spi_miso  (spi_miso)
);

// File: tb/test_mcdac_spi_regs.sv
`timescale 1ns/1ps
module test_mcdac_spi_regs;

    localparam int NCH = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic csn = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_n;
    logic [NCH*16-1:0] code, code_n;
    logic [NCH*14-1:0] ofs, ofs_n;
    logic pd, pd_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mcdac_spi_regs i_mcdac_spi_regs (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .chan_code(code), .chan_ofs_dac(ofs), .pwr_down(pd)
    );

    mcdac_spi_regs #(.CODE_BITS(14)) i_mcdac_spi_regs_n14 (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso_n), .chan_code(code_n), .chan_ofs_dac(ofs_n), .pwr_down(pd_n)
    );

    // {requirement, write frame, readback request, expected readback}
    localparam logic [71:0] VEC [12] = '{
        {8'd2, 24'hC81234, 24'h050400, 16'h1234},  // R2 code ch0
        {8'd3, 24'h8BA5A5, 24'h054580, 16'hA5A5},  // R3 offset trim ch3
        {8'd3, 24'h5F0F0F, 24'h056F80, 16'h0F0F},  // R3 gain trim ch23
        {8'd9, 24'hCDBEEF, 24'h052680, 16'hBEEF},  // R9 alternate code type
        {8'd5, 24'h02FFFF, 24'h058100, 16'h3FFF},  // R5 group 0 DAC, top bits dropped
        {8'd4, 24'h010001, 24'h058080, 16'h0001},  // R4 control set
        {8'd4, 24'h010000, 24'h058080, 16'h0000},  // R4 control clear
        {8'd9, 24'hE07777, 24'h051000, 16'h0000},  // R9 channel past NUM_CH
        {8'd9, 24'hC31111, 24'h050180, 16'h0000},  // R9 unmapped low address
        {8'd9, 24'h041234, 24'h058200, 16'h0000},  // R9 absent group 2
        {8'd5, 24'h030555, 24'h058180, 16'h0555},  // R5 group 1 DAC
        {8'd9, 24'h000000, 24'h05A400, 16'h0000}   // R9 reserved type
    };

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [23:0] f, input int nbits, output logic [23:0] rx);
        rx = '0;
        csn = 1'b0;
        wclk(10);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? f[23-i] : 1'b0;
            sclk = 1'b1;
            wclk(10);
            rx = {rx[22:0], miso};
            sclk = 1'b0;
            wclk(10);
        end
        wclk(6);
        csn = 1'b1;
        wclk(20);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] rx;
        wclk(5);
        rst = 1'b0;
        wclk(5);

        // R8: reset state at the ports
        for (int i = 0; i < NCH; i++) begin
            chk("R8 code reset", 32'(code[i*16 +: 16]), 32'h8000);
            chk("R8 group dac reset", 32'(ofs[i*14 +: 14]), 32'h2000);
        end
        chk("R8 pwr_down reset", 32'(pd), 32'h0);
        chk("R8 miso idle", 32'(miso), 32'h0);
        chk("R8 narrow code reset", 32'(code_n[0 +: 16]), 32'h8000);

        // R8: gain and offset trims after reset, via readback
        xfer(24'h056400, 24, rx);
        xfer(24'h000000, 24, rx);
        chk("R8 gain reset ch0", 32'(rx), 32'h00FFFF);
        xfer(24'h054480, 24, rx);
        xfer(24'h000000, 24, rx);
        chk("R8 offset trim reset ch1", 32'(rx), 32'h008000);

        // vector table: write, request readback, collect
        for (int v = 0; v < 12; v++) begin
            xfer(VEC[v][63:40], 24, rx);
            xfer(VEC[v][39:16], 24, rx);
            xfer(24'h000000, 24, rx);
            chk($sformatf("R%0d R6 vector %0d readback", VEC[v][71:64], v),
                32'(rx), {16'h0, VEC[v][15:0]});
        end

        // R2 / R9 / R10 at the ports after the table
        chk("R2 code ch0", 32'(code[0 +: 16]), 32'h1234);
        chk("R2 code ch5", 32'(code[5*16 +: 16]), 32'hBEEF);
        chk("R9 ch23 code untouched", 32'(code[23*16 +: 16]), 32'h8000);
        chk("R10 narrow ch5 low bits", 32'(code_n[5*16 +: 16]), 32'hBEEC);
        chk("R10 narrow ch0", 32'(code_n[0 +: 16]), 32'h1234);

        // R7: group mapping with clamp to last group
        chk("R7 ch0 group0", 32'(ofs[0 +: 14]), 32'h3FFF);
        chk("R7 ch7 group0", 32'(ofs[7*14 +: 14]), 32'h3FFF);
        chk("R7 ch8 group1", 32'(ofs[8*14 +: 14]), 32'h0555);
        chk("R7 ch16 clamped", 32'(ofs[16*14 +: 14]), 32'h0555);
        chk("R7 ch23 clamped", 32'(ofs[23*14 +: 14]), 32'h0555);

        // R4: power-down follows bit 0 only
        xfer(24'h010001, 24, rx);
        chk("R4 pwr_down set", 32'(pd), 32'h1);
        xfer(24'h010002, 24, rx);
        chk("R4 pwr_down clear with bit1 set", 32'(pd), 32'h0);

        // R1: short and long frames are discarded
        xfer(24'hC95555, 23, rx);
        chk("R1 short frame ignored", 32'(code[1*16 +: 16]), 32'h8000);
        xfer(24'hC95555, 25, rx);
        chk("R1 long frame ignored", 32'(code[1*16 +: 16]), 32'h8000);
        xfer(24'hC95555, 24, rx);
        chk("R1 full frame committed", 32'(code[1*16 +: 16]), 32'h5555);

        // R6: readback while writing, then zero after a plain write
        xfer(24'h050480, 24, rx);
        xfer(24'hC90001, 24, rx);
        chk("R6 readback during write", 32'(rx), 32'h005555);
        chk("R2 write during readback frame", 32'(code[1*16 +: 16]), 32'h0001);
        xfer(24'h000000, 24, rx);
        chk("R6 zero after non-readback frame", 32'(rx), 32'h000000);
        chk("R6 miso idle after frame", 32'(miso), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule